// File: doc/BRIEF.md
# Dual-Version Line Storage Array

This block models the data array of a cache in which each row keeps two bit-planes behind a single row address. The upper plane is the working copy and the lower plane is the shadow copy. In transactional use, the upper plane holds the speculative new value and the lower plane holds the committed old value. Either plane can be read or written on its own. One command writes the same line into both planes. A line can be copied from one plane to the other inside its row. A single broadcast command copies the upper plane of every row into its lower plane.

A client presents one command per cycle. Each command is a 3-bit operation code qualified by a valid strobe, a row index and a line of write data. Every operation takes effect at the clock edge on which it is presented. Read data is registered and appears one cycle after the read command. It keeps its value until the next read. Because every copy finishes in one cycle, a read in the following cycle already sees the copied value. Tags, hit logic, replacement and refill are handled elsewhere.

Top module: `dual_version_array`

## Requirements
- R1: With the default CLEAR_ON_RESET=1, reset clears `rd_data` and both planes of every row to zero.
- R2: Operation codes are 0 upper read, 1 upper write, 2 lower read, 3 lower write, 4 store, 5 restore, 6 dual write and 7 store-all. An upper write stores `wr_data` in the upper plane of row `row_idx`. An upper read returns that row's upper plane on `rd_data` one cycle after it is accepted.
- R3: A lower write or lower read acts on the lower plane only. A write to one plane leaves the other plane of the same row unchanged.
- R4: Store (code 4) copies the upper plane of the addressed row into its lower plane. It leaves that row's upper plane and every other row unchanged.
- R5: Restore (code 5) copies the lower plane of the addressed row into its upper plane. It leaves that row's lower plane and every other row unchanged.
- R6: Dual write (code 6) writes `wr_data` into both planes of the addressed row.
- R7: Store-all (code 7) copies the upper plane into the lower plane in every row in one cycle. It ignores `row_idx` and leaves all upper planes unchanged.
- R8: `rd_data` holds its value on every cycle without an accepted read. A command presented with `op_valid` low changes no storage.
- R9: A read issued in the cycle right after a store, restore or store-all returns the copied value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the command for this cycle |
| op_code | input | 3 | Operation code |
| row_idx | input | $clog2(ROWS) | Addressed row |
| wr_data | input | LINE_W | Line of write data |
| rd_data | output | LINE_W | Registered line of read data |

## Verification
Assertions next to the storage check on every cycle the following:
- A row that is not addressed, and is not swept by store-all, keeps both planes.
- Each copy delivers the source plane into the destination plane at the next edge.
- A dual write leaves two identical planes.
- Read data changes only after an accepted read, and then matches the addressed plane.

Other properties are only visible through the bench's directed scenarios against its own per-plane reference:
- Idle commands leave storage untouched.
- Store-all ignores the row index.
- A read in the cycle right after a copy returns the new data.
- The encodings of the operation codes are correct.

// File: rtl/dva_pkg.sv
package dva_pkg;

   typedef enum logic [2:0] {
      OP_UP_RD    = 3'd0,
      OP_UP_WR    = 3'd1,
      OP_LO_RD    = 3'd2,
      OP_LO_WR    = 3'd3,
      OP_SAVE     = 3'd4,
      OP_RECOVER  = 3'd5,
      OP_BOTH_WR  = 3'd6,
      OP_SAVE_ALL = 3'd7
   } dva_op_e;

   typedef struct packed {
      logic up_wr;       // write upper plane of the selected row
      logic lo_wr;       // write lower plane of the selected row
      logic up_from_lo;  // restore: lower to upper, selected row
      logic lo_from_up;  // store: upper to lower, selected row
      logic all_save;    // store upper to lower in every row
      logic rd_up;       // read upper plane
      logic rd_lo;       // read lower plane
   } dva_ctl_t;

endpackage

// File: rtl/dva_decode.sv
module dva_decode
   import dva_pkg::*;
(
   input  logic       op_valid,
   input  logic [2:0] op_code,
   output dva_ctl_t   ctl
);

   always_comb begin
      ctl = '0;
      if (op_valid) begin
         case (dva_op_e'(op_code))
            OP_UP_RD:    ctl.rd_up      = 1'b1;
            OP_UP_WR:    ctl.up_wr      = 1'b1;
            OP_LO_RD:    ctl.rd_lo      = 1'b1;
            OP_LO_WR:    ctl.lo_wr      = 1'b1;
            OP_SAVE:     ctl.lo_from_up = 1'b1;
            OP_RECOVER:  ctl.up_from_lo = 1'b1;
            OP_BOTH_WR: begin
               ctl.up_wr = 1'b1;
               ctl.lo_wr = 1'b1;
            end
            OP_SAVE_ALL: ctl.all_save   = 1'b1;
            default:     ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/dva_row.sv
module dva_row #(
   parameter int LINE_W         = 512,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              up_wr,
   input  logic              lo_wr,
   input  logic              up_from_lo,
   input  logic              lo_from_up,
   input  logic              all_save,
   input  logic [LINE_W-1:0] wr_data,
   output logic [LINE_W-1:0] upper_q,
   output logic [LINE_W-1:0] lower_q
);

   logic              up_en, lo_en;
   logic [LINE_W-1:0] up_d, lo_d;

   always_comb begin
      up_en = sel & (up_wr | up_from_lo);
      up_d  = up_wr ? wr_data : lower_q;
      lo_en = (sel & (lo_wr | lo_from_up)) | all_save;
      lo_d  = (sel & lo_wr) ? wr_data : upper_q;
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               upper_q <= '0;
               lower_q <= '0;
            end else begin
               if (up_en) upper_q <= up_d;
               if (lo_en) lower_q <= lo_d;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (up_en) upper_q <= up_d;
            if (lo_en) lower_q <= lo_d;
         end
      end
   endgenerate

   // R4: line store lands the old upper plane in the lower plane
   a_r4_store_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && lo_from_up) |=> (lower_q == $past(upper_q)) && $stable(upper_q));

   // R5: restore lands the old lower plane in the upper plane
   a_r5_restore_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && up_from_lo) |=> (upper_q == $past(lower_q)) && $stable(lower_q));

   // R6: dual write leaves both planes equal to the written line
   a_r6_dual_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && up_wr && lo_wr) |=> (upper_q == lower_q) && (upper_q == $past(wr_data)));

   // R7: broadcast store reaches every row and keeps the upper plane
   a_r7_all_copies: assert property (@(posedge clk) disable iff (!rst_n)
      all_save |=> (lower_q == $past(upper_q)) && $stable(upper_q));

   // R3 / R8: an untouched row keeps both planes
   a_r8_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_save && !(sel && (up_wr || lo_wr || up_from_lo || lo_from_up)))
         |=> $stable(upper_q) && $stable(lower_q));

endmodule

// File: rtl/dva_read_port.sv
module dva_read_port #(
   parameter int ROWS   = 16,
   parameter int LINE_W = 512,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_up,
   input  logic              rd_lo,
   input  logic [IDX_W-1:0]  row_idx,
   input  logic [LINE_W-1:0] upper_rows [ROWS],
   input  logic [LINE_W-1:0] lower_rows [ROWS],
   output logic [LINE_W-1:0] rd_data
);

   logic [LINE_W-1:0] sel_line;

   always_comb begin
      sel_line = rd_lo ? lower_rows[row_idx] : upper_rows[row_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              rd_data <= '0;
      else if (rd_up || rd_lo) rd_data <= sel_line;
   end

   // R8: output is held on cycles without an accepted read
   a_r8_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_up || rd_lo) |=> $stable(rd_data));

   // R2: upper read returns the addressed upper line one cycle later
   a_r2_upper_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_up |=> rd_data == $past(upper_rows[row_idx]));

   // R3: lower read returns the addressed lower line one cycle later
   a_r3_lower_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> rd_data == $past(lower_rows[row_idx]));

   // R2: at most one read kind is decoded per cycle
   a_r2_one_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_up && rd_lo));

endmodule

// File: rtl/dual_version_array.sv
module dual_version_array
   import dva_pkg::*;
#(
   parameter int ROWS           = 16,
   parameter int LINE_W         = 512,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [IDX_W-1:0]  row_idx,
   input  logic [LINE_W-1:0] wr_data,
   output logic [LINE_W-1:0] rd_data
);

   generate
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("dual_version_array: ROWS must be a power of two, at least 2");
      end
      if (LINE_W < 1) begin : g_bad_width
         $error("dual_version_array: LINE_W must be positive");
      end
   endgenerate

   dva_ctl_t          ctl;
   logic [LINE_W-1:0] upper_rows [ROWS];
   logic [LINE_W-1:0] lower_rows [ROWS];

   dva_decode u_decode (
      .op_valid (op_valid),
      .op_code  (op_code),
      .ctl      (ctl)
   );

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic hit;
         assign hit = (row_idx == IDX_W'(r));

         dva_row #(
            .LINE_W         (LINE_W),
            .CLEAR_ON_RESET (CLEAR_ON_RESET)
         ) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (hit),
            .up_wr      (ctl.up_wr),
            .lo_wr      (ctl.lo_wr),
            .up_from_lo (ctl.up_from_lo),
            .lo_from_up (ctl.lo_from_up),
            .all_save   (ctl.all_save),
            .wr_data    (wr_data),
            .upper_q    (upper_rows[r]),
            .lower_q    (lower_rows[r])
         );
      end
   endgenerate

   dva_read_port #(
      .ROWS   (ROWS),
      .LINE_W (LINE_W),
      .IDX_W  (IDX_W)
   ) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_up      (ctl.rd_up),
      .rd_lo      (ctl.rd_lo),
      .row_idx    (row_idx),
      .upper_rows (upper_rows),
      .lower_rows (lower_rows),
      .rd_data    (rd_data)
   );

   // R2: decoded command is at most one storage action or read per cycle
   a_r2_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ctl.up_wr | ctl.lo_wr, ctl.up_from_lo, ctl.lo_from_up,
                  ctl.all_save, ctl.rd_up, ctl.rd_lo}) <= 1);

   // R8: no action is decoded without the valid strobe
   a_r8_idle_no_action: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (ctl == '0));

endmodule

// File: tb/test_dual_version_array.sv
module test_dual_version_array;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS       = 16;
   localparam int LW         = 512;
   localparam int IW         = $clog2(ROWS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op_code = '0;
   logic [IW-1:0] row_idx = '0;
   logic [LW-1:0] wr_data = '0;
   logic [LW-1:0] rd_data;

   logic [LW-1:0] ref_up [ROWS];
   logic [LW-1:0] ref_lo [ROWS];

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_version_array #(.ROWS(ROWS), .LINE_W(LW)) i_dual_version_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .row_idx  (row_idx),
      .wr_data  (wr_data),
      .rd_data  (rd_data)
   );

   function automatic logic [LW-1:0] pat(int s);
      logic [LW-1:0] v;
      for (int k = 0; k < LW/32; k++) v[k*32 +: 32] = (32'(s) * 32'd7919 + 32'(k)) * 32'h9E37_79B9;
      return v;
   endfunction

   task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(bit vld, logic [2:0] op, int row, logic [LW-1:0] d);
      @(negedge clk);
      op_valid = vld;
      op_code  = op;
      row_idx  = IW'(row);
      wr_data  = d;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
   endtask

   task automatic rd_chk(bit lower, int row, string req);
      issue(1'b1, lower ? 3'd2 : 3'd0, row, '0);
      chk(req, rd_data, lower ? ref_lo[row] : ref_up[row]);
   endtask

   task automatic t_reset();
      for (int r = 0; r < ROWS; r++) begin
         rd_chk(1'b0, r, "R1");
         rd_chk(1'b1, r, "R1");
      end
   endtask

   task automatic t_upper();
      int rows[3] = '{0, 5, ROWS-1};
      foreach (rows[i]) begin
         issue(1'b1, 3'd1, rows[i], pat(10 + i));
         ref_up[rows[i]] = pat(10 + i);
      end
      foreach (rows[i]) begin
         rd_chk(1'b0, rows[i], "R2");
         rd_chk(1'b1, rows[i], "R3");
      end
   endtask

   task automatic t_lower();
      for (int r = 0; r < 4; r++) begin
         issue(1'b1, 3'd3, r, pat(20 + r));
         ref_lo[r] = pat(20 + r);
      end
      for (int r = 0; r < 4; r++) begin
         rd_chk(1'b1, r, "R3");
         rd_chk(1'b0, r, "R3");
      end
   endtask

   task automatic t_store();
      issue(1'b1, 3'd4, 5, pat(99));
      ref_lo[5] = ref_up[5];
      rd_chk(1'b1, 5, "R9");
      rd_chk(1'b0, 5, "R4");
      rd_chk(1'b1, 0, "R4");
      rd_chk(1'b1, 6, "R4");
   endtask

   task automatic t_restore();
      issue(1'b1, 3'd1, 2, pat(30));
      ref_up[2] = pat(30);
      issue(1'b1, 3'd5, 2, pat(98));
      ref_up[2] = ref_lo[2];
      rd_chk(1'b0, 2, "R9");
      rd_chk(1'b1, 2, "R5");
      rd_chk(1'b0, 3, "R5");
   endtask

   task automatic t_dual();
      issue(1'b1, 3'd6, 9, pat(40));
      ref_up[9] = pat(40);
      ref_lo[9] = pat(40);
      rd_chk(1'b0, 9, "R6");
      rd_chk(1'b1, 9, "R6");
      rd_chk(1'b1, 8, "R6");
   endtask

   task automatic t_store_all();
      for (int r = 0; r < ROWS; r++) begin
         issue(1'b1, 3'd1, r, pat(50 + r));
         ref_up[r] = pat(50 + r);
         issue(1'b1, 3'd3, r, pat(80 + r));
         ref_lo[r] = pat(80 + r);
      end
      issue(1'b1, 3'd7, 3, pat(97));
      for (int r = 0; r < ROWS; r++) ref_lo[r] = ref_up[r];
      rd_chk(1'b1, ROWS-1, "R9");
      for (int r = 0; r < ROWS; r++) begin
         rd_chk(1'b1, r, "R7");
         rd_chk(1'b0, r, "R7");
      end
   endtask

   task automatic t_hold();
      logic [LW-1:0] held;
      rd_chk(1'b0, 5, "R8");
      held = rd_data;
      issue(1'b0, 3'd1, 5, pat(60));
      chk("R8", rd_data, held);
      issue(1'b0, 3'd6, 4, pat(61));
      issue(1'b0, 3'd7, 0, pat(62));
      issue(1'b1, 3'd3, 7, pat(63));
      ref_lo[7] = pat(63);
      chk("R8", rd_data, held);
      issue(1'b1, 3'd4, 1, pat(64));
      ref_lo[1] = ref_up[1];
      chk("R8", rd_data, held);
      rd_chk(1'b0, 5, "R8");
      rd_chk(1'b1, 4, "R8");
      rd_chk(1'b0, 4, "R8");
      rd_chk(1'b1, 0, "R8");
      rd_chk(1'b1, 7, "R3");
      rd_chk(1'b1, 1, "R4");
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) begin
         ref_up[r] = '0;
         ref_lo[r] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1", rd_data, '0);
      t_reset();
      t_upper();
      t_lower();
      t_store();
      t_restore();
      t_dual();
      t_store_all();
      t_hold();
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

endmodule